// File: doc/BRIEF.md
# Return-State Save/Restore Sequencer

This block carries out the two-word memory transfer behind an exception-return style operation on a 32-bit memory port. In save mode it pushes the link value and then the saved status word onto a stack addressed from a base register. In restore mode it reads a new program counter and then a new status word from that stack. At the end it asks the register file to take the status word and to branch.

Mode codes are checked before any access. A hypervisor current mode raises an undefined-instruction flag. A user or system current mode, or a save aimed at the hypervisor stack, raises an unpredictable flag. In both cases nothing goes to memory and no writeback is offered. After a restore, the loaded status word is checked again, and one particular mode/state combination suppresses the branch.

The block issues one word request per beat with a valid/ready handshake. It reports completion with a one-cycle done pulse, and the optional base writeback value arrives with that pulse.

Top module: `rsx_seq`

## Requirements
- R1: The first beat address is `base` when `incr`=1 and `base-8` when `incr`=0 (modulo 2^32). With `word_hi`=1, 4 is added to it. The second beat address is the first plus 4.
- R2: In save mode (`op_restore`=0), both beats have `mem_write`=1. Beat one carries `link_val` and beat two carries `stat_val`.
- R3: In restore mode (`op_restore`=1), both beats have `mem_write`=0. The first read word appears on `new_pc` and the second on `new_stat`.
- R4: With `wback`=1, `wb_valid` pulses together with `done`. `wb_value` then equals `base+8` when incrementing and `base-8` when decrementing. `wb_valid` stays low when `wback`=0 and on any pre-transfer abort.
- R5: If `cur_mode` is 5'b11010 when a start is accepted, the next cycle shows `done`=1 and `undef`=1 with `unpred`=0, and no memory request is ever made for that operation.
- R6: If `cur_mode` is user (5'b10000) or system (5'b11111) in either mode, or a save has `tgt_mode`=5'b11010, the next cycle shows `done`=1 and `unpred`=1 with no memory request.
- R7: After a restore, `stat_wr` pulses with `done`. If the loaded status word has mode bits [4:0]=5'b11010 and both bit 24 (J) and bit 5 (T) set, `unpred`=1 and `branch`=0. Otherwise `branch`=1 and `unpred`=0. A save never asserts `stat_wr` or `branch`.
- R8: A request holds its address, data and direction until accepted. `done` is a single-cycle pulse in the cycle after the final handshake. A `start` raised while `busy`=1 is ignored.
- R9: After synchronous reset, `busy`, `done`, `mem_valid`, `undef`, `unpred`, `wb_valid`, `stat_wr` and `branch` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_restore | input | 1 | 1 = restore (read), 0 = save (write) |
| incr | input | 1 | 1 = increment addressing, 0 = decrement |
| word_hi | input | 1 | Add one word to the start address |
| wback | input | 1 | Request base writeback |
| base | input | 32 | Base register value |
| cur_mode | input | 5 | Current mode code |
| tgt_mode | input | 5 | Target stack mode code for save |
| link_val | input | 32 | Link value to save |
| stat_val | input | 32 | Saved status word to save |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | Request is a write |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rdata | input | 32 | Read data, valid with the accepting handshake |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | Undefined-instruction flag, with done |
| unpred | output | 1 | Unpredictable flag, with done |
| wb_valid | output | 1 | Base writeback offered, with done |
| wb_value | output | 32 | Base writeback value |
| stat_wr | output | 1 | Status write request, with done |
| branch | output | 1 | Branch request, with done |
| new_pc | output | 32 | Loaded program counter |
| new_stat | output | 32 | Loaded status word |

## Verification
The hardest case to reach from the ports is a start request that lands while a transfer is stalled. The bench reaches it by holding `mem_ready` low with a rotating stall pattern and pulsing `start` mid-transfer with a hypervisor mode code, which would abort at once if it were sampled. The post-restore check is also hard to reach, because it depends on data the memory returns. The bench's memory model returns status words drawn from a small set, each with a different combination of the hypervisor mode code and the J and T bits. The sweep covers every 5-bit current mode against every flag combination in both directions, with bases placed so that the ±8 arithmetic wraps.

// File: rtl/rsx_pkg.sv
package rsx_pkg;
  localparam int MODE_W = 5;
  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;
  localparam logic [MODE_W-1:0] MODE_HYP = 5'b11010;
  localparam int T_POS = 5;
  localparam int J_POS = 24;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } rsx_state_e;
endpackage

// File: rtl/rsx_addr_gen.sv
module rsx_addr_gen #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic [AW-1:0] base,
  input  logic          incr,
  input  logic          word_hi,
  output logic [AW-1:0] first_addr,
  output logic [AW-1:0] next_base
);
  localparam int WORD_BYTES = DW / 8;
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);
  localparam logic [AW-1:0] SPAN = AW'(2 * WORD_BYTES);

  logic [AW-1:0] lowest;

  always_comb begin
    lowest     = incr ? base : (base - SPAN);
    first_addr = word_hi ? (lowest + STEP) : lowest;
    next_base  = incr ? (base + SPAN) : (base - SPAN);
  end
endmodule

// File: rtl/rsx_pre_chk.sv
module rsx_pre_chk
  import rsx_pkg::*;
(
  input  logic              restore,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] tgt_mode,
  output logic              is_undef,
  output logic              is_unpred
);
  logic unpriv;

  always_comb begin
    unpriv    = (cur_mode == MODE_USR) || (cur_mode == MODE_SYS);
    is_undef  = (cur_mode == MODE_HYP);
    is_unpred = !is_undef && (unpriv || (!restore && (tgt_mode == MODE_HYP)));
  end
endmodule

// File: rtl/rsx_ret_chk.sv
module rsx_ret_chk
  import rsx_pkg::*;
(
  input  logic [MODE_W-1:0] ld_mode,
  input  logic              ld_j,
  input  logic              ld_t,
  output logic              no_branch
);
  always_comb no_branch = (ld_mode == MODE_HYP) && ld_j && ld_t;
endmodule

// File: rtl/rsx_seq.sv
module rsx_seq
  import rsx_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_restore,
  input  logic              incr,
  input  logic              word_hi,
  input  logic              wback,
  input  logic [AW-1:0]     base,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] tgt_mode,
  input  logic [DW-1:0]     link_val,
  input  logic [DW-1:0]     stat_val,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ready,
  input  logic [DW-1:0]     mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              undef,
  output logic              unpred,
  output logic              wb_valid,
  output logic [AW-1:0]     wb_value,
  output logic              stat_wr,
  output logic              branch,
  output logic [DW-1:0]     new_pc,
  output logic [DW-1:0]     new_stat
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  rsx_state_e    st;
  logic          op_r, wback_r;
  logic [AW-1:0] addr_r, wbv_r;
  logic [DW-1:0] wdata_r, stat_hold;

  logic [AW-1:0] first_c, nbase_c;
  logic          undef_c, unpred_c, ret_bad;

  rsx_addr_gen #(.AW(AW), .DW(DW)) u_addr (
    .base(base), .incr(incr), .word_hi(word_hi),
    .first_addr(first_c), .next_base(nbase_c)
  );

  rsx_pre_chk u_pre (
    .restore(op_restore), .cur_mode(cur_mode), .tgt_mode(tgt_mode),
    .is_undef(undef_c), .is_unpred(unpred_c)
  );

  rsx_ret_chk u_ret (
    .ld_mode(mem_rdata[MODE_W-1:0]), .ld_j(mem_rdata[J_POS]),
    .ld_t(mem_rdata[T_POS]), .no_branch(ret_bad)
  );

  assign busy      = (st != ST_IDLE);
  assign mem_valid = busy;
  assign mem_write = busy && !op_r;
  assign mem_addr  = addr_r;
  assign mem_wdata = wdata_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      op_r      <= 1'b0;
      wback_r   <= 1'b0;
      addr_r    <= '0;
      wbv_r     <= '0;
      wdata_r   <= '0;
      stat_hold <= '0;
      done      <= 1'b0;
      undef     <= 1'b0;
      unpred    <= 1'b0;
      wb_valid  <= 1'b0;
      wb_value  <= '0;
      stat_wr   <= 1'b0;
      branch    <= 1'b0;
      new_pc    <= '0;
      new_stat  <= '0;
    end else begin
      done     <= 1'b0;
      undef    <= 1'b0;
      unpred   <= 1'b0;
      wb_valid <= 1'b0;
      stat_wr  <= 1'b0;
      branch   <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (undef_c) begin
              done  <= 1'b1;
              undef <= 1'b1;
            end else if (unpred_c) begin
              done   <= 1'b1;
              unpred <= 1'b1;
            end else begin
              st        <= ST_LO;
              op_r      <= op_restore;
              wback_r   <= wback;
              addr_r    <= first_c;
              wbv_r     <= nbase_c;
              wdata_r   <= link_val;
              stat_hold <= stat_val;
            end
          end
        end
        ST_LO: begin
          if (mem_ready) begin
            st      <= ST_HI;
            addr_r  <= addr_r + STEP;
            wdata_r <= stat_hold;
            if (op_r) new_pc <= mem_rdata;
          end
        end
        ST_HI: begin
          if (mem_ready) begin
            st       <= ST_IDLE;
            done     <= 1'b1;
            wb_valid <= wback_r;
            if (wback_r) wb_value <= wbv_r;
            if (op_r) begin
              new_stat <= mem_rdata;
              stat_wr  <= 1'b1;
              if (ret_bad) unpred <= 1'b1;
              else         branch <= 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rsx_chk.sv
module rsx_chk
  import rsx_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              op_restore,
  input logic              incr,
  input logic              word_hi,
  input logic [AW-1:0]     base,
  input logic [MODE_W-1:0] cur_mode,
  input logic              mem_valid,
  input logic              mem_write,
  input logic [AW-1:0]     mem_addr,
  input logic [DW-1:0]     mem_wdata,
  input logic              mem_ready,
  input logic              busy,
  input logic              done,
  input logic              undef,
  input logic              unpred,
  input logic              wb_valid,
  input logic              stat_wr,
  input logic              branch
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  logic [AW-1:0] exp_first;
  logic          op_q, second_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_first <= '0;
      op_q      <= 1'b0;
      second_q  <= 1'b0;
    end else begin
      if (start && !busy) begin
        exp_first <= base - (incr ? '0 : (STEP + STEP)) + (word_hi ? STEP : '0);
        op_q      <= op_restore;
        second_q  <= 1'b0;
      end else if (mem_valid && mem_ready) begin
        second_q <= !second_q;
      end
    end
  end

  a_r1_first_addr: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_valid) |-> (mem_addr == exp_first));

  a_r1_second_addr: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && !second_q) |=> (mem_valid && (mem_addr == $past(mem_addr) + STEP)));

  a_r3_direction: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_write == !op_q));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_write)));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r5_undef_quiet: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (cur_mode == MODE_HYP)) |=> (done && undef && !unpred && !mem_valid));

  a_r4_no_wb_abort: assert property (@(posedge clk) disable iff (rst)
    (undef || (unpred && !stat_wr)) |-> !wb_valid);

  a_r7_branch_excl: assert property (@(posedge clk) disable iff (rst)
    branch |-> (done && stat_wr && !unpred));
endmodule

bind rsx_seq rsx_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op_restore(op_restore),
  .incr(incr), .word_hi(word_hi), .base(base), .cur_mode(cur_mode),
  .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready), .busy(busy), .done(done),
  .undef(undef), .unpred(unpred), .wb_valid(wb_valid), .stat_wr(stat_wr),
  .branch(branch)
);

// File: tb/sim_rsx_seq.sv
`timescale 1ns/1ps
module sim_rsx_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, op_restore = 1'b0, incr = 1'b0, word_hi = 1'b0, wback = 1'b0;
  logic [31:0] base = '0, link_val = '0, stat_val = '0;
  logic [4:0]  cur_mode = '0, tgt_mode = '0;
  logic        mem_valid, mem_write, mem_ready = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, done, undef, unpred, wb_valid, stat_wr, branch;
  logic [31:0] wb_value, new_pc, new_stat;

  logic [31:0] exp_first = '0, rd_pc = '0, rd_st = '0;
  int          stall_mode = 0, cyc = 0, nlog = 0;
  logic [31:0] log_addr [2];
  logic [31:0] log_data [2];
  logic        log_wr   [2];
  int          checks = 0, fails = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  rsx_seq u0 (
    .clk(clk), .rst(rst), .start(start), .op_restore(op_restore), .incr(incr),
    .word_hi(word_hi), .wback(wback), .base(base), .cur_mode(cur_mode),
    .tgt_mode(tgt_mode), .link_val(link_val), .stat_val(stat_val),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .undef(undef), .unpred(unpred),
    .wb_valid(wb_valid), .wb_value(wb_value), .stat_wr(stat_wr),
    .branch(branch), .new_pc(new_pc), .new_stat(new_stat)
  );

  assign mem_rdata = (mem_addr == exp_first) ? rd_pc : rd_st;

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (nlog < 2) begin
        log_addr[nlog] <= mem_addr;
        log_data[nlog] <= mem_wdata;
        log_wr[nlog]   <= mem_write;
      end
      nlog <= nlog + 1;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= (stall_mode == 0) ? 1'b1 : (((cyc + stall_mode) % 3) != 0);
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit rs, input bit inc, input bit wh, input bit wb,
                        input logic [31:0] b, input logic [4:0] cm, input logic [4:0] tm,
                        input logic [31:0] lk, input logic [31:0] sv, input logic [31:0] ldst,
                        input int stall, input bit poke);
    logic [31:0] fa, nb, ldpc;
    bit e_undef, e_pre, acc, e_bad;
    int n;
    fa = (inc ? b : b - 32'd8) + (wh ? 32'd4 : 32'd0);
    nb = inc ? b + 32'd8 : b - 32'd8;
    ldpc = fa ^ 32'h5A00_0001;
    e_undef = (cm == 5'b11010);
    e_pre = !e_undef && ((cm == 5'b10000) || (cm == 5'b11111) || (!rs && tm == 5'b11010));
    acc = !e_undef && !e_pre;
    e_bad = rs && acc && (ldst[4:0] == 5'b11010) && ldst[24] && ldst[5];
    @(negedge clk);
    exp_first = fa; rd_pc = ldpc; rd_st = ldst; stall_mode = stall;
    op_restore = rs; incr = inc; word_hi = wh; wback = wb; base = b;
    cur_mode = cm; tgt_mode = tm; link_val = lk; stat_val = sv;
    nlog = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 60) begin
      if (poke && n == 0 && busy) begin
        start = 1'b1; cur_mode = 5'b11010;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(done, "R8 done", {31'd0, done}, 32'd1);
    check(undef == e_undef, "R5 undef", {31'd0, undef}, {31'd0, e_undef});
    check(unpred == (e_pre || e_bad), "R6/R7 unpred", {31'd0, unpred}, {31'd0, e_pre || e_bad});
    check(wb_valid == (acc && wb), "R4 wb_valid", {31'd0, wb_valid}, {31'd0, acc && wb});
    if (acc && wb) check(wb_value == nb, "R4 wb_value", wb_value, nb);
    check(nlog == (acc ? 2 : 0), "R5/R6 beat count", nlog, acc ? 2 : 0);
    check(stat_wr == (rs && acc), "R7 stat_wr", {31'd0, stat_wr}, {31'd0, rs && acc});
    check(branch == (rs && acc && !e_bad), "R7 branch", {31'd0, branch}, {31'd0, rs && acc && !e_bad});
    if (acc) begin
      check(log_addr[0] == fa, "R1 first addr", log_addr[0], fa);
      check(log_addr[1] == fa + 32'd4, "R1 second addr", log_addr[1], fa + 32'd4);
      check(log_wr[0] == !rs && log_wr[1] == !rs, "R2/R3 direction", {31'd0, log_wr[0]}, {31'd0, !rs});
      if (!rs) begin
        check(log_data[0] == lk, "R2 link word", log_data[0], lk);
        check(log_data[1] == sv, "R2 status word", log_data[1], sv);
      end else begin
        check(new_pc == ldpc, "R3 new_pc", new_pc, ldpc);
        check(new_stat == ldst, "R3 new_stat", new_stat, ldst);
      end
    end
    @(negedge clk);
    check(!done, "R8 done single", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] sts [4];
    sts[0] = 32'h0100_003A;
    sts[1] = 32'h0000_003A;
    sts[2] = 32'h0100_0033;
    sts[3] = 32'h0000_0010;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !mem_valid && !undef && !unpred && !wb_valid && !stat_wr && !branch,
          "R9 reset state", {24'd0, busy, done, mem_valid, undef, unpred, wb_valid, stat_wr, branch}, 32'd0);
    for (int op = 0; op < 2; op++) begin
      for (int cm = 0; cm < 32; cm++) begin
        for (int f = 0; f < 8; f++) begin
          logic [31:0] b;
          logic [4:0] tm;
          b  = (cm == 3) ? 32'h0000_0004 : (cm == 5) ? 32'hFFFF_FFFC : 32'h2000_0000 + 32'(cm * 64 + f * 16);
          tm = (cm % 2 == 1) ? 5'b11010 : 5'b10011;
          run_op(op[0], f[0], f[1], f[2], b, cm[4:0], tm,
                 32'hC0DE_0000 + 32'(cm * 8 + f), 32'h6000_0000 + 32'(cm + f * 32),
                 sts[(cm + f) % 4], (cm + f) % 3, (f == 5) && (cm % 4 == 2));
        end
      end
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule